// File: doc/BRIEF.md
# MSI Pending/Queued Delivery Gate

The gate takes one message-signalled interrupt request at a time, identified by a source number, and decides from that source's vector entry whether the interrupt goes to the presenter. The vector entries live in an external table in memory. The gate computes the entry address from a table configuration: an enable bit, a length, a base address and an entry-size select. It then reads the 64-bit entry over a simple request/response memory port.

The two status bits in the entry are P (pending) and Q (queued). Together with the priority byte, they pick one of three actions. The gate can drop the request. It can set Q with a byte write. Or it can set P with a byte write and then pulse a delivery strobe. The strobe carries the target server, the source number and the priority. A force input makes the gate treat the stored P/Q pair as 00. This is used when an earlier rejected interrupt is retried.

The state machine has six states. S_IDLE accepts a request. S_RD_REQ issues the entry read. S_RD_WAIT waits for the read data and makes the decision. S_WR_REQ issues the status byte write. S_WR_WAIT waits for the write acknowledge. S_DELIVER pulses the strobe.

The transitions are as follows:
- S_IDLE moves to S_RD_REQ on an accepted in-range request, and stays in S_IDLE when the request is abandoned.
- S_RD_REQ moves to S_RD_WAIT once the memory accepts the read.
- S_RD_WAIT returns to S_IDLE on an error or a drop, and moves to S_WR_REQ otherwise.
- S_WR_REQ moves to S_WR_WAIT once the memory accepts the write.
- S_WR_WAIT returns to S_IDLE on an error or after a Q write, and moves to S_DELIVER after a P write.
- S_DELIVER always returns to S_IDLE.

Top module: `msi_pq_gate`

## Requirements
- R1: An accepted request is abandoned when `cfg_tbl_en` is 0 or `req_src` >= `cfg_tbl_len`. The gate then makes no memory access, gives no strobe, and `busy` stays 0 with `req_ready` back at 1 in the next cycle.
- R2: The entry read is issued at address (`cfg_tbl_base` with bits [3:0] cleared) + `req_src` × 16, or + `req_src` × 128 when `cfg_wide_entry` is 1. Byte writes go to that address + 4 (P byte) or + 5 (Q byte).
- R3: The entry is a big-endian 64-bit word. The raw server is bits [63:48], and the delivered server is raw >> 2, which is 14 bits. Generation is bits [26:25], P is bit 24, Q is bit 16, and priority is bits [7:0].
- R4: With P=0, Q=0 and priority not 0xFF, the gate writes the byte {5'b0, gen, 1'b1} to the P address. After the write acknowledge, it pulses the delivery strobe.
- R5: With P=0, Q=0 and priority 0xFF (masked), the gate writes 0x01 to the Q address and gives no strobe.
- R6: With P=1 and Q=0, the gate writes 0x01 to the Q address and gives no strobe.
- R7: With Q=1, the gate makes no write and gives no strobe.
- R8: When `req_force` is 1, the stored P and Q bits are ignored and treated as 00.
- R9: The gate handles one request at a time. From the cycle after acceptance until it returns to idle, `busy` is 1 and `req_ready` is 0.
- R10: An error response to the read or to the write ends the sequence, with no further write and no strobe.
- R11: `dlv_valid` is high for exactly one cycle, the cycle after the P-write acknowledge. It carries the server, the source and the priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request present |
| req_ready | output | 1 | Gate is idle and takes the request |
| req_src | input | SRC_W | Source number |
| req_force | input | 1 | Ignore the stored P/Q state |
| cfg_tbl_en | input | 1 | Vector table enabled |
| cfg_tbl_len | input | SRC_W+1 | Number of entries in the table |
| cfg_tbl_base | input | ADDR_W | Table base address; low 4 bits are ignored |
| cfg_wide_entry | input | 1 | 128-byte entry stride when 1, 16-byte stride when 0 |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a byte write, 0 for a 64-bit read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 64 | Read data, big-endian entry word |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_server | output | 14 | Target server |
| dlv_src | output | SRC_W | Delivered source number |
| dlv_prio | output | 8 | Delivered priority |

## Verification
With a memory that is always ready and answers one cycle after each request, the timing is fixed:
- The read request appears in the cycle after acceptance.
- The write request appears two cycles after the read request.
- The strobe appears one cycle after the write acknowledge.

The driver pushes the expected read, write and delivery events into a queue before it raises the request. A monitor samples at the falling edge and pops one event for each memory request or strobe it sees. It checks the strobe cycle against a cycle counter taken at the write acknowledge. After each request the driver waits for `busy` to fall and then two more cycles before it checks that the queue is empty. This catches a missing event as well as an extra one.

// File: rtl/msi_gate_pkg.sv
package msi_gate_pkg;
    localparam int WORD_W     = 64;
    localparam int SRV_W      = 14;
    localparam int PRIO_W     = 8;
    localparam int GEN_W      = 2;
    localparam int ALIGN_BITS = 4;
    localparam int NARROW_SH  = 4;
    localparam int WIDE_SH    = 7;
    localparam int P_OFS      = 4;
    localparam int Q_OFS      = 5;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_DELIVER
    } gate_state_e;

    typedef enum logic [1:0] {
        ACT_DROP, ACT_SET_Q, ACT_SET_P
    } pq_action_e;
endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr
    import msi_gate_pkg::*;
#(
    parameter int SRC_W  = 11,
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              wide,
    input  logic [SRC_W-1:0]  src,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BASE_MASK =
        {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        src_ext = ADDR_W'(src);
        offset  = wide ? (src_ext << WIDE_SH) : (src_ext << NARROW_SH);
        addr    = (base & BASE_MASK) + offset;
    end
endmodule

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
    import msi_gate_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              force_pq,
    output pq_action_e        action,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic [GEN_W-1:0]  gen
);
    logic p_bit, q_bit;
    logic unused_bits;

    always_comb begin
        server = word[63:50];
        gen    = word[26:25];
        prio   = word[7:0];
        p_bit  = word[24] & ~force_pq;
        q_bit  = word[16] & ~force_pq;
        unique case ({p_bit, q_bit})
            2'b00:   action = (prio == PRIO_MASKED) ? ACT_SET_Q : ACT_SET_P;
            2'b10:   action = ACT_SET_Q;
            default: action = ACT_DROP;
        endcase
    end

    assign unused_bits = ^{word[49:27], word[23:17], word[15:8]};
endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
    import msi_gate_pkg::*;
#(
    parameter int SRC_W  = 11,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SRC_W-1:0]  req_src,
    input  logic              req_force,
    input  logic              cfg_tbl_en,
    input  logic [SRC_W:0]    cfg_tbl_len,
    input  logic [ADDR_W-1:0] cfg_tbl_base,
    input  logic              cfg_wide_entry,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              dlv_valid,
    output logic [SRV_W-1:0]  dlv_server,
    output logic [SRC_W-1:0]  dlv_src,
    output logic [PRIO_W-1:0] dlv_prio
);
    gate_state_e       state, state_nx;
    logic [ADDR_W-1:0] ent_addr_c, ent_addr_q;
    logic [SRC_W-1:0]  src_q;
    logic              force_q;
    pq_action_e        act_c, act_q;
    logic [SRV_W-1:0]  srv_c, srv_q;
    logic [PRIO_W-1:0] prio_c, prio_q;
    logic [GEN_W-1:0]  gen_c, gen_q;
    logic              in_range, accept;

    msi_entry_addr #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_addr (
        .base(cfg_tbl_base), .wide(cfg_wide_entry), .src(req_src), .addr(ent_addr_c)
    );

    msi_pq_decide u_decide (
        .word(mem_rsp_data), .force_pq(force_q), .action(act_c),
        .server(srv_c), .prio(prio_c), .gen(gen_c)
    );

    assign accept   = req_valid && (state == S_IDLE);
    assign in_range = cfg_tbl_en && ({1'b0, req_src} < cfg_tbl_len);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (accept && in_range) state_nx = S_RD_REQ;
            S_RD_REQ:  if (mem_req_ready) state_nx = S_RD_WAIT;
            S_RD_WAIT: if (mem_rsp_valid)
                           state_nx = (mem_rsp_err || act_c == ACT_DROP) ? S_IDLE : S_WR_REQ;
            S_WR_REQ:  if (mem_req_ready) state_nx = S_WR_WAIT;
            S_WR_WAIT: if (mem_rsp_valid)
                           state_nx = (!mem_rsp_err && act_q == ACT_SET_P) ? S_DELIVER : S_IDLE;
            S_DELIVER: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // request and entry context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr_q <= '0;
            src_q      <= '0;
            force_q    <= 1'b0;
            act_q      <= ACT_DROP;
            srv_q      <= '0;
            prio_q     <= '0;
            gen_q      <= '0;
        end else begin
            if (accept) begin
                ent_addr_q <= ent_addr_c;
                src_q      <= req_src;
                force_q    <= req_force;
            end
            if (state == S_RD_WAIT && mem_rsp_valid) begin
                act_q  <= act_c;
                srv_q  <= srv_c;
                prio_q <= prio_c;
                gen_q  <= gen_c;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == S_IDLE);
        busy          = (state != S_IDLE);
        mem_req_valid = (state == S_RD_REQ) || (state == S_WR_REQ);
        mem_req_write = (state == S_WR_REQ);
        mem_req_addr  = ent_addr_q;
        mem_req_wdata = 8'h01;
        if (state == S_WR_REQ) begin
            if (act_q == ACT_SET_P) begin
                mem_req_addr  = ent_addr_q + ADDR_W'(P_OFS);
                mem_req_wdata = {5'b0, gen_q, 1'b1};
            end else begin
                mem_req_addr  = ent_addr_q + ADDR_W'(Q_OFS);
            end
        end
        dlv_valid  = (state == S_DELIVER);
        dlv_server = srv_q;
        dlv_src    = src_q;
        dlv_prio   = prio_q;
    end

    a_r1_abandon: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!cfg_tbl_en || {1'b0, req_src} >= cfg_tbl_len))
        |=> (!busy && !mem_req_valid));

    a_r9_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_tbl_en && {1'b0, req_src} < cfg_tbl_len)
        |=> (busy && !req_ready));

    a_r2_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_write ? (mem_req_addr[3:0] == 4'd4 || mem_req_addr[3:0] == 4'd5)
                                         : (mem_req_addr[3:0] == 4'd0)));

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7 and R10: Q already set or a read error ends the sequence
    a_r7_q_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_WAIT && mem_rsp_valid && (mem_rsp_err || (!force_q && mem_rsp_data[16])))
        |=> (state == S_IDLE));

    a_r11_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> $past(mem_rsp_valid && !mem_rsp_err && state == S_WR_WAIT));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid);

    a_r5_no_masked_dlv: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != PRIO_MASKED));
endmodule

// File: tb/msi_pq_gate_tb.sv
module msi_pq_gate_tb;
    localparam int SRC_W  = 11;
    localparam int ADDR_W = 48;

    typedef struct packed {
        logic [1:0]        kind;   // 0 read, 1 write, 2 delivery
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [13:0]       srv;
        logic [SRC_W-1:0]  src;
        logic [7:0]        prio;
    } ev_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_force = 0, req_ready, busy;
    logic [SRC_W-1:0] req_src = '0;
    logic cfg_tbl_en = 1, cfg_wide_entry = 0;
    logic [SRC_W:0] cfg_tbl_len = 12'd64;
    logic [ADDR_W-1:0] cfg_tbl_base = 48'h0000_1000_0003;
    logic mem_req_valid, mem_req_write, mem_req_ready = 1;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [7:0] mem_req_wdata;
    logic mem_rsp_valid = 0, mem_rsp_err = 0, rsp_is_wr = 0;
    logic [63:0] mem_rsp_data = '0;
    logic dlv_valid;
    logic [13:0] dlv_server;
    logic [SRC_W-1:0] dlv_src;
    logic [7:0] dlv_prio;

    logic [63:0] tbl_word = '0;
    logic rd_err = 0, wr_err = 0;
    int cyc = 0, wack_cyc = -10;
    int n_chk = 0, n_fail = 0;
    ev_t exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    msi_pq_gate #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_force(req_force), .cfg_tbl_en(cfg_tbl_en),
        .cfg_tbl_len(cfg_tbl_len), .cfg_tbl_base(cfg_tbl_base),
        .cfg_wide_entry(cfg_wide_entry), .busy(busy), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_data(mem_rsp_data), .dlv_valid(dlv_valid), .dlv_server(dlv_server),
        .dlv_src(dlv_src), .dlv_prio(dlv_prio)
    );

    // memory model: always ready, answers one cycle after each request
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_rsp_valid <= 0;
        end else begin
            mem_rsp_valid <= mem_req_valid;
            rsp_is_wr     <= mem_req_write;
            mem_rsp_err   <= mem_req_write ? wr_err : rd_err;
            mem_rsp_data  <= tbl_word;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected event per observed memory request or strobe
    always @(negedge clk) begin
        if (rst_n) begin
            ev_t ev;
            bit seen;
            seen = 0;
            ev = '0;
            if (mem_rsp_valid && rsp_is_wr) wack_cyc = cyc;
            if (mem_req_valid && mem_req_ready) begin
                seen = 1;
                ev.kind = mem_req_write ? 2'd1 : 2'd0;
                ev.addr = mem_req_addr;
                ev.data = mem_req_write ? mem_req_wdata : 8'h00;
            end else if (dlv_valid) begin
                seen = 1;
                ev.kind = 2'd2;
                ev.srv = dlv_server;
                ev.src = dlv_src;
                ev.prio = dlv_prio;
                chk(cyc == wack_cyc + 1, "R11", "strobe cycle", 128'(cyc), 128'(wack_cyc + 1));
            end
            if (seen) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected event", 128'(ev), 128'(0));
                end else begin
                    ev_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(ev == e, t, "event", 128'(ev), 128'(e));
                end
            end
        end
    end

    function automatic logic [63:0] mkword(input logic [15:0] srv, input logic [1:0] gen,
                                           input logic p, input logic q, input logic [7:0] prio);
        return {srv, 16'h0, 5'b0, gen, p, 7'b0, q, 8'h00, prio};
    endfunction

    // reference: expected events from the requirements
    task automatic push_expected(input logic [SRC_W-1:0] src, input logic frc, input string tag);
        logic [ADDR_W-1:0] a;
        logic p, q;
        ev_t e;
        if (!cfg_tbl_en || {1'b0, src} >= cfg_tbl_len) return;             // R1
        a = (cfg_tbl_base & ~48'hF) + (48'(src) << (cfg_wide_entry ? 7 : 4)); // R2
        e = '0; e.kind = 0; e.addr = a;
        exp_q.push_back(e); tag_q.push_back("R2");
        if (rd_err) return;                                                  // R10
        p = tbl_word[24] & ~frc;                                             // R3, R8
        q = tbl_word[16] & ~frc;
        if (q) return;                                                       // R7
        e = '0; e.kind = 1;
        if (p || tbl_word[7:0] == 8'hFF) begin                               // R5, R6
            e.addr = a + 5; e.data = 8'h01;
            exp_q.push_back(e); tag_q.push_back(tag);
        end else begin                                                       // R4
            e.addr = a + 4; e.data = {5'b0, tbl_word[26:25], 1'b1};
            exp_q.push_back(e); tag_q.push_back(tag);
            if (wr_err) return;
            e = '0; e.kind = 2; e.srv = tbl_word[63:50]; e.src = src; e.prio = tbl_word[7:0];
            exp_q.push_back(e); tag_q.push_back("R11");
        end
    endtask

    task automatic send(input logic [SRC_W-1:0] src, input logic frc, input logic [63:0] w,
                        input logic re, input logic we, input string tag);
        bit takes;
        @(negedge clk);
        tbl_word = w; rd_err = re; wr_err = we;
        takes = cfg_tbl_en && ({1'b0, src} < cfg_tbl_len);
        push_expected(src, frc, tag);
        req_src = src; req_force = frc; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (takes) begin
            chk(busy && !req_ready, "R9", "busy after accept", 128'({busy, req_ready}), 128'(2'b10));
        end else begin
            chk(!busy && req_ready, "R1", "idle after abandon", 128'({busy, req_ready}), 128'(2'b01));
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, tag, "missing events", 128'(exp_q.size()), 128'(0));
        exp_q.delete(); tag_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R9", "watchdog expired", 128'(cyc), 128'(0));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req_valid && !dlv_valid, "R9", "reset outputs",
            128'({busy, mem_req_valid, dlv_valid}), 128'(0));
        rst_n = 1;
        @(negedge clk);
        chk(req_ready, "R9", "ready out of reset", 128'(req_ready), 128'(1));

        send(11'd5,  0, mkword(16'h1234, 2'd2, 0, 0, 8'h20), 0, 0, "R4");  // deliver
        send(11'd63, 0, mkword(16'hFFFF, 2'd3, 0, 0, 8'h01), 0, 0, "R3");  // last entry, field edges
        cfg_wide_entry = 1;
        send(11'd3,  0, mkword(16'h0AB7, 2'd1, 0, 0, 8'h07), 0, 0, "R2");  // wide stride
        cfg_wide_entry = 0;
        send(11'd9,  0, mkword(16'h0040, 2'd0, 0, 0, 8'hFF), 0, 0, "R5");  // masked
        send(11'd10, 0, mkword(16'h0040, 2'd1, 1, 0, 8'h11), 0, 0, "R6");  // pending
        send(11'd11, 0, mkword(16'h0040, 2'd1, 0, 1, 8'h11), 0, 0, "R7");  // queued
        send(11'd12, 0, mkword(16'h0040, 2'd1, 1, 1, 8'h11), 0, 0, "R7");
        send(11'd13, 1, mkword(16'h5550, 2'd2, 1, 1, 8'h10), 0, 0, "R8");  // force
        send(11'd14, 1, mkword(16'h5550, 2'd2, 1, 0, 8'hFF), 0, 0, "R8");  // force, masked
        send(11'd64, 0, mkword(16'h1111, 2'd0, 0, 0, 8'h01), 0, 0, "R1");  // at length
        cfg_tbl_en = 0;
        send(11'd2,  0, mkword(16'h1111, 2'd0, 0, 0, 8'h01), 0, 0, "R1");  // disabled
        cfg_tbl_en = 1;
        send(11'd20, 0, mkword(16'h2222, 2'd0, 0, 0, 8'h02), 1, 0, "R10"); // read error
        send(11'd21, 0, mkword(16'h2222, 2'd0, 0, 0, 8'h02), 0, 1, "R10"); // write error
        cfg_tbl_base = 48'h0000_0ABC_DEF0;
        send(11'd0,  0, mkword(16'h0004, 2'd1, 0, 0, 8'h00), 0, 0, "R4");  // src 0, prio 0

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule